// File: doc/BRIEF.md
# Triggered Synchronous Clock Gate

This block regenerates a clock that restarts in a fixed relation to an external trigger. A source clock is offered as eight equally spaced phase taps, sampled by a fast clock running eight times faster than the source, so one source period spans eight fast cycles. The trigger pin is XORed with a polarity select; while that qualified trigger sits at its suspend level, the synchronous clock and the one-shot pulse are held low and the complementary clock is held high. When the trigger is released, the clock starts again on the next rising edge of the reference tap. From the third output edge onward, the clock follows the tap chosen by a 3-bit phase code, so the output is delayed by zero to seven eighth-period steps.

A one-shot pulse marks the first two output periods after each restart. An output-enable pin forces the complementary clock and the pulse inactive. A free-running copy of the reference tap is always driven, untouched by trigger and phase code. After reset the block ignores the first trigger and reports not-ready until a second trigger has been seen.

Top module: `trig_sync_gate`

## Requirements
- R1: The qualified trigger is trig_i XOR pol_i; its suspend level is 0 (trig_i equal to pol_i). With pol_i=1 a falling trig_i edge releases the gate, with pol_i=0 a rising edge does.
- R2: While suspended, clk_o=0, pulse_o=0 and clk_n_o=1, and these levels return within six fast cycles of the trigger going back to its suspend level.
- R3: After release, the first rising edge of clk_o coincides with a rising edge of cont_clk_o (reference tap 0 delayed one fast cycle), no more than 18 fast cycles after release, and the following falling edge of clk_o coincides with the next falling edge of tap 0.
- R4: With phase code k, the second rising edge of clk_o comes 8+k fast cycles after the first and the third 16+k after the first; from the second rising edge on, clk_o equals tap k delayed by one fast cycle.
- R5: The phase code is captured at release; changing phase_i while the gate runs has no effect on clk_o.
- R6: pulse_o rises together with the first rising edge of clk_o and falls together with the third, so it is high for 16+k fast cycles.
- R7: With oe_i=0, clk_n_o is the logical inverse of clk_o.
- R8: With oe_i=1, clk_n_o=1 and pulse_o=0, while clk_o still runs.
- R9: After reset not_ready_o=1 and the outputs stay idle through the first trigger release; not_ready_o falls and the gate runs from the second release on.
- R10: cont_clk_o equals tap 0 delayed one fast cycle at all times, independent of trigger, polarity and phase code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock, NTAP cycles per source period |
| rst_n | input | 1 | Asynchronous active-low reset |
| taps_i | input | NTAP | Phase taps of the source clock, tap k lags tap 0 by k eighths |
| trig_i | input | 1 | External trigger |
| pol_i | input | 1 | Trigger polarity select (1: falling edge releases) |
| oe_i | input | 1 | High forces clk_n_o high and pulse_o low |
| phase_i | input | CODE_W | Phase delay code in eighth-period steps |
| clk_o | output | 1 | Synchronous clock |
| clk_n_o | output | 1 | Complement of the synchronous clock |
| pulse_o | output | 1 | One-shot pulse over the first two output periods |
| cont_clk_o | output | 1 | Free-running copy of tap 0 |
| not_ready_o | output | 1 | High until the second trigger release after reset |

## Verification
The bench releases the trigger at varying offsets against the source phase, with both polarities and several phase codes including 0 and 7, and measures the first, second and third rising edges of the clock and the pulse width; a gate that shifted the first edges, switched taps mid-period or counted the pulse from the wrong edge shows a wrong gap or width. It changes the phase code in the middle of a run, which a design sampling the code live would follow, and it raises the output enable over a whole burst so a pulse that leaks through is seen. The first trigger after reset must produce no clock at all, catching a design that starts too early, and every suspend must bring back the idle levels.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_FIRST,
    ST_GAPA,
    ST_GAPB,
    ST_RUN
  } gate_st_e;
endpackage

// File: rtl/tsg_trig_qual.sv
module tsg_trig_qual #(
  parameter int SYNC_STAGES  = 2,
  parameter int READY_AFTER  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic pol_i,
  output logic run_lvl_o,
  output logic ready_o
);
  localparam int CNT_W = $clog2(READY_AFTER + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(READY_AFTER);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q;
  logic [CNT_W-1:0]       seen_q, seen_d;
  logic                   start;

  // qualified trigger enters the synchronizer chain
  assign sync_d[0] = trig_i ^ pol_i;
  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    assign sync_d[i] = sync_q[i-1];
  end

  assign run_lvl_o = sync_q[SYNC_STAGES-1];
  assign start     = run_lvl_o & ~last_q;
  assign ready_o   = (seen_q == CNT_MAX);

  always_comb begin
    seen_d = seen_q;
    if (start && (seen_q != CNT_MAX)) seen_d = seen_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
      seen_q <= '0;
    end else begin
      sync_q <= sync_d;
      last_q <= run_lvl_o;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/tsg_phase_sel.sv
module tsg_phase_sel #(
  parameter int NTAP   = 8,
  parameter int CODE_W = $clog2(NTAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTAP-1:0]   taps_i,
  input  logic              code_ld_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tap0_rise_o,
  output logic              tap0_fall_o,
  output logic              sel_lvl_o,
  output logic              sel_rise_o,
  output logic              code_zero_o,
  output logic              cont_o
);
  logic [NTAP-1:0]   tap_q, tap_prev_q;
  logic [CODE_W-1:0] code_q, code_d;
  logic              cont_q;

  always_comb begin
    code_d = code_q;
    if (code_ld_i) code_d = code_i;
  end

  assign tap0_rise_o = tap_q[0] & ~tap_prev_q[0];
  assign tap0_fall_o = ~tap_q[0] & tap_prev_q[0];
  assign sel_lvl_o   = tap_q[code_q];
  assign sel_rise_o  = tap_q[code_q] & ~tap_prev_q[code_q];
  assign code_zero_o = (code_q == '0);
  assign cont_o      = cont_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q      <= '0;
      tap_prev_q <= '0;
      code_q     <= '0;
      cont_q     <= 1'b0;
    end else begin
      tap_q      <= taps_i;
      tap_prev_q <= tap_q;
      code_q     <= code_d;
      cont_q     <= tap_q[0];
    end
  end
endmodule

// File: rtl/tsg_gate_fsm.sv
module tsg_gate_fsm
  import tsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_lvl_i,
  input  logic ready_i,
  input  logic tap0_rise_i,
  input  logic tap0_fall_i,
  input  logic sel_lvl_i,
  input  logic sel_rise_i,
  input  logic code_zero_i,
  output logic code_ld_o,
  output logic clk_q_o,
  output logic pulse_q_o
);
  gate_st_e st_q, st_d;
  logic     clk_q, clk_d;
  logic     pulse_q, pulse_d;

  always_comb begin
    st_d      = st_q;
    clk_d     = clk_q;
    pulse_d   = pulse_q;
    code_ld_o = 1'b0;
    if (!run_lvl_i) begin
      st_d    = ST_IDLE;
      clk_d   = 1'b0;
      pulse_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          clk_d   = 1'b0;
          pulse_d = 1'b0;
          if (ready_i) begin
            st_d      = ST_ARMED;
            code_ld_o = 1'b1;
          end
        end
        ST_ARMED: begin
          if (tap0_rise_i) begin
            st_d    = ST_FIRST;
            clk_d   = 1'b1;
            pulse_d = 1'b1;
          end
        end
        ST_FIRST: begin
          if (tap0_fall_i) begin
            st_d  = ST_GAPA;
            clk_d = 1'b0;
          end
        end
        ST_GAPA: begin
          if (tap0_rise_i) begin
            if (code_zero_i) begin
              st_d  = ST_RUN;
              clk_d = 1'b1;
            end else begin
              st_d = ST_GAPB;
            end
          end
        end
        ST_GAPB: begin
          if (sel_rise_i) begin
            st_d  = ST_RUN;
            clk_d = 1'b1;
          end
        end
        ST_RUN: begin
          clk_d = sel_lvl_i;
          if (sel_rise_i) pulse_d = 1'b0;
        end
        default: begin
          st_d    = ST_IDLE;
          clk_d   = 1'b0;
          pulse_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      clk_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      clk_q   <= clk_d;
      pulse_q <= pulse_d;
    end
  end

  assign clk_q_o   = clk_q;
  assign pulse_q_o = pulse_q;

  assert_suspend_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_lvl_i |=> (!clk_q && !pulse_q));

  assert_not_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> (!clk_q && !pulse_q));

  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $rose(clk_q));

  assert_pulse_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_q) |-> ($rose(clk_q) || !$past(run_lvl_i)));

  assert_rise_on_tap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> $past(tap0_rise_i || sel_rise_i));
endmodule

// File: rtl/trig_sync_gate.sv
module trig_sync_gate #(
  parameter int NTAP        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int READY_AFTER = 2,
  localparam int CODE_W     = $clog2(NTAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTAP-1:0]   taps_i,
  input  logic              trig_i,
  input  logic              pol_i,
  input  logic              oe_i,
  input  logic [CODE_W-1:0] phase_i,
  output logic              clk_o,
  output logic              clk_n_o,
  output logic              pulse_o,
  output logic              cont_clk_o,
  output logic              not_ready_o
);
  logic run_lvl, ready;
  logic tap0_rise, tap0_fall, sel_lvl, sel_rise, code_zero, code_ld;
  logic gclk, gpulse;

  tsg_trig_qual #(
    .SYNC_STAGES(SYNC_STAGES),
    .READY_AFTER(READY_AFTER)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig_i),
    .pol_i    (pol_i),
    .run_lvl_o(run_lvl),
    .ready_o  (ready)
  );

  tsg_phase_sel #(
    .NTAP  (NTAP),
    .CODE_W(CODE_W)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .taps_i     (taps_i),
    .code_ld_i  (code_ld),
    .code_i     (phase_i),
    .tap0_rise_o(tap0_rise),
    .tap0_fall_o(tap0_fall),
    .sel_lvl_o  (sel_lvl),
    .sel_rise_o (sel_rise),
    .code_zero_o(code_zero),
    .cont_o     (cont_clk_o)
  );

  tsg_gate_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_lvl_i  (run_lvl),
    .ready_i    (ready),
    .tap0_rise_i(tap0_rise),
    .tap0_fall_i(tap0_fall),
    .sel_lvl_i  (sel_lvl),
    .sel_rise_i (sel_rise),
    .code_zero_i(code_zero),
    .code_ld_o  (code_ld),
    .clk_q_o    (gclk),
    .pulse_q_o  (gpulse)
  );

  assign clk_o       = gclk;
  assign clk_n_o     = oe_i ? 1'b1 : ~gclk;
  assign pulse_o     = oe_i ? 1'b0 : gpulse;
  assign not_ready_o = ~ready;

  assert_cont_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cont_clk_o) |-> $past(tap0_rise));
endmodule

// File: tb/trig_sync_gate_tb.sv
module trig_sync_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NTAP = 8;

  logic       clk, rst_n;
  logic [7:0] taps_i;
  logic       trig_i, pol_i, oe_i;
  logic [2:0] phase_i;
  logic       clk_o, clk_n_o, pulse_o, cont_clk_o, not_ready_o;

  trig_sync_gate u_dut (
    .clk(clk), .rst_n(rst_n), .taps_i(taps_i), .trig_i(trig_i), .pol_i(pol_i),
    .oe_i(oe_i), .phase_i(phase_i), .clk_o(clk_o), .clk_n_o(clk_n_o),
    .pulse_o(pulse_o), .cont_clk_o(cont_clk_o), .not_ready_o(not_ready_o)
  );

  typedef struct { int k; bit oe; } exp_t;
  exp_t exp_q[$];
  exp_t cur;

  int  n_chk = 0, n_fail = 0;
  int  ph = 0, cyc = 0, rel_cyc = 0;
  int  mstate = 0, t0 = 0, t1 = 0, phigh = 0;
  bit  in_burst = 0, run_hold = 0, burst_ok = 0, phase_chg = 0, done = 0;
  bit  prev_clk = 0;

  function automatic logic tapv(int p, int k);
    return (((p - k) & 7) < 4);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end

  // monitor and tap source
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc > 3) begin
        check(cont_clk_o == tapv(ph-1, 0), "R10 continuous clock", cont_clk_o, tapv(ph-1, 0));
        if (oe_i) check(clk_n_o && !pulse_o, "R8 forced inactive", {clk_n_o, pulse_o}, 2);
        else      check(clk_n_o == !clk_o, "R7 inversion", clk_n_o, !clk_o);
      end
      if (!in_burst) begin
        mstate = 0;
        if (clk_o && !prev_clk) check(0, "R9 unexpected clock edge", 1, 0);
      end else begin
        case (mstate)
          0: if (exp_q.size() > 0) begin cur = exp_q.pop_front(); mstate = 1; end
          default: ;
        endcase
        case (mstate)
          1: if (clk_o && !prev_clk) begin
               t0 = cyc;
               check(tapv(ph-1, 0) && !tapv(ph-2, 0), "R3 first edge on tap0 rise", tapv(ph-1,0), 1);
               check(t0 - rel_cyc <= 18, "R3 restart latency", t0 - rel_cyc, 18);
               check(pulse_o == !cur.oe, "R6 pulse starts with clock", pulse_o, !cur.oe);
               phigh = pulse_o;
               burst_ok = 1;
               mstate = 2;
             end
          2: begin
               if (!clk_o && prev_clk)
                 check(!tapv(ph-1, 0) && tapv(ph-2, 0), "R3 second edge on tap0 fall", tapv(ph-1,0), 0);
               if (clk_o && !prev_clk) begin
                 t1 = cyc;
                 check(t1 - t0 == 8 + cur.k, "R4 second rise gap", t1 - t0, 8 + cur.k);
                 mstate = 3;
               end
               phigh += pulse_o;
             end
          3: if (clk_o && !prev_clk) begin
               check(cyc - t0 == 16 + cur.k, "R4 third rise gap", cyc - t0, 16 + cur.k);
               check(phigh == (cur.oe ? 0 : 16 + cur.k), "R6 pulse width", phigh, cur.oe ? 0 : 16 + cur.k);
               check(!pulse_o, "R6 pulse ends at third rise", pulse_o, 0);
               mstate = 4;
             end else phigh += pulse_o;
          4: if (run_hold) begin
               if (phase_chg) check(clk_o == tapv(ph-1, cur.k), "R5 code held", clk_o, tapv(ph-1, cur.k));
               else           check(clk_o == tapv(ph-1, cur.k), "R4 follows tap", clk_o, tapv(ph-1, cur.k));
             end
          default: ;
        endcase
      end
    end
    prev_clk = clk_o;
    ph = ph + 1;
    for (int k = 0; k < NTAP; k++) taps_i[k] = tapv(ph, k);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check_idle(input string req);
    check(!clk_o && !pulse_o && clk_n_o, req, {clk_o, pulse_o, clk_n_o}, 1);
  endtask

  task automatic burst(input bit p, input int k, input bit oe, input int pre);
    exp_t e;
    wait_cyc(1);
    pol_i = p; trig_i = p; oe_i = oe; phase_i = 3'(k); phase_chg = 0;
    wait_cyc(12 + pre);
    check_idle("R2 idle before release");
    e.k = k; e.oe = oe;
    exp_q.push_back(e);
    burst_ok = 0; in_burst = 1; run_hold = 1; rel_cyc = cyc;
    trig_i = ~p;
    wait_cyc(50);
    check(burst_ok, "R1 release edge starts clock", burst_ok, 1);
    check(mstate == 4, "R4 burst reached run", mstate, 4);
    phase_i = 3'(k) ^ 3'b101; phase_chg = 1;
    wait_cyc(20);
    trig_i = p; run_hold = 0;
    wait_cyc(6);
    check_idle("R2 idle after suspend");
    in_burst = 0; oe_i = 0;
  endtask

  initial begin
    for (int k = 0; k < NTAP; k++) taps_i[k] = tapv(0, k);
    rst_n = 0; trig_i = 0; pol_i = 0; oe_i = 0; phase_i = 0;
    repeat (5) @(negedge clk);
    #1; rst_n = 1;
    wait_cyc(2);
    check(not_ready_o, "R9 not ready after reset", not_ready_o, 1);
    check_idle("R9 idle after reset");
    trig_i = 1;
    wait_cyc(30);
    check(not_ready_o, "R9 first trigger ignored", not_ready_o, 1);
    check_idle("R9 idle on first trigger");
    trig_i = 0;
    wait_cyc(10);
    burst(1'b0, 0, 1'b0, 3);
    check(!not_ready_o, "R9 ready after second trigger", not_ready_o, 0);
    burst(1'b1, 3, 1'b0, 5);
    burst(1'b0, 7, 1'b0, 1);
    burst(1'b1, 5, 1'b0, 0);
    burst(1'b0, 2, 1'b1, 2);
    burst(1'b1, 1, 1'b0, 6);
    burst(1'b1, 7, 1'b1, 4);
    burst(1'b0, 4, 1'b0, 7);
    wait_cyc(5);
    finish_up();
  end
endmodule